// File: doc/BRIEF.md
# Security State Monitor

This block follows the security posture of a device from reset onward. After reset it leaves its idle entry state, checks how the device booted, and then climbs a ladder of trust levels. Each step up the ladder needs a software register write. Each state decides which key material the crypto engines may use. Violations can come from several places: hardware sources, a software declaration, or the wrap of an internal monotonic counter. When a violation occurs in a trusted state, the block falls into a failure state. That state locks keys out, requests that they be cleared and raises an interrupt. If the configuration asks for the stronger response, it also requests a reset and a memory wipe.

The surrounding chip has three jobs. It wires the boot-source flag. It ties the active-low tamper pin high when no tamper circuit is fitted. It routes the key, interrupt and reset outputs to the key store, the interrupt controller and the reset logic. The failure states are left only through reset.

Top module: `sec_state_mon`

## Requirements
- R1: While rst_n is low, state_o reads 0 (Init) and all key, interrupt and request outputs are low. At the first clock edge with rst_n high, state_o becomes 1 (Check).
- R2: In Check, if boot_ext is high or any violation is present (hash_fail, dbg_viol, synchronized tamper, counter wrap or sw_soft_fail), the next state is 2 (Non-Secure). In Non-Secure only key_test_en is high.
- R3: In Check with no violation, sw_trust_wr moves the state to 3 (Trusted). In Trusted with no violation, sw_secure_wr moves it to 4 (Secure). key_master_en is high in both states, and key_test_en is low in both.
- R4: sw_secure_wr has no effect in Check. sw_trust_wr has no effect in Trusted or Secure.
- R5: In Trusted or Secure with hard_fail_en low, any violation moves the state to 5 (Soft Fail). There key_master_en and key_test_en are low and key_lockout and irq are high. key_clear is high for exactly the first cycle in that state.
- R6: In Trusted or Secure with hard_fail_en high, any violation moves the state to 6 (Hard Fail). Hard Fail has every Soft Fail output, and reset_req and zeroize_req are high as well.
- R7: In Soft Fail, a violation with hard_fail_en high moves the state to Hard Fail and pulses key_clear again. In every other case Soft Fail and Hard Fail hold until reset.
- R8: tamper_n low counts as a violation only after two synchronizer flops. A low level driven before clock edge k changes state_o at edge k+2.
- R9: cnt_value increments on each cycle in which cnt_inc is high and wraps from all ones to zero. The wrap counts as a violation in the cycle that follows it.
- R10: A violation that arrives in the same cycle as sw_trust_wr or sw_secure_wr takes priority over the write.
- R11: Non-Secure ignores violations and software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_ext | input | 1 | Device booted from an unverified external source |
| tamper_n | input | 1 | Asynchronous tamper pin, low means tampered |
| hash_fail | input | 1 | Runtime hash check mismatch |
| dbg_viol | input | 1 | Debug controller violation |
| cnt_inc | input | 1 | Increment the monotonic counter |
| sw_trust_wr | input | 1 | Software write setting the trust bit |
| sw_secure_wr | input | 1 | Software write setting the secure bit |
| sw_soft_fail | input | 1 | Software-declared violation |
| hard_fail_en | input | 1 | Select the hard failure response |
| state_o | output | 3 | Current state code (0 to 6) |
| key_test_en | output | 1 | Test key may be used |
| key_master_en | output | 1 | Master key and key-encryption key may be used |
| key_clear | output | 1 | One-cycle strobe to clear master and key-encryption keys |
| key_lockout | output | 1 | All key use blocked |
| irq | output | 1 | Violation interrupt |
| reset_req | output | 1 | Device reset request |
| zeroize_req | output | 1 | Memory wipe request |
| cnt_value | output | CNT_W | Monotonic counter value |

## Verification
The bench builds the block with CNT_W set to 4. With that width the counter wraps after sixteen increments, so the wrap-as-violation path can be reached in every scenario instead of after 2^48 cycles. With a counter that narrow, the bench can sweep both trusted states against all five violation sources and both failure responses. It also checks that a write and a violation arriving together resolve as required, and it confirms the exact two-flop delay on the tamper pin.

// File: rtl/sec_state_pkg.sv
// Package: shared state encoding for the security state monitor.
// Assumes: codes are visible on state_o and must stay stable for software.
package sec_state_pkg;
    typedef enum logic [2:0] {
        ST_INIT     = 3'd0,
        ST_CHECK    = 3'd1,
        ST_NONSEC   = 3'd2,
        ST_TRUSTED  = 3'd3,
        ST_SECURE   = 3'd4,
        ST_SOFTFAIL = 3'd5,
        ST_HARDFAIL = 3'd6
    } sec_state_e;
endpackage

// File: rtl/sec_tamper_sync.sv
// Module: brings the asynchronous active-low tamper pin into the clock
// domain through a chain of flops and presents it as an active-high flag.
// Assumes: STAGES >= 2; the pin idles high, so the chain resets to high.
module sec_tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tamper_n,
    output logic tamper_viol
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], tamper_n};
    end

    assign tamper_viol = ~chain_q[STAGES-1];
endmodule

// File: rtl/sec_mono_counter.sv
// Module: free-running monotonic counter advanced by an increment strobe.
// A wrap from all ones to zero gives a registered one-cycle pulse.
// Assumes: the wrap pulse is consumed as a violation by the state machine.
module sec_mono_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             wrap_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;

    // Advance the count and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= inc && (cnt_q == CNT_MAX);
            if (inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value      = cnt_q;
    assign wrap_pulse = wrap_q;

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1) && !wrap_q);
    // R9
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == CNT_MAX) |=> (cnt_q == '0) && wrap_q);
    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/sec_state_fsm.sv
// Module: the trust ladder. It moves from Init through Check to
// Non-Secure, Trusted or Secure, and falls to Soft or Hard Fail on a
// violation. Key and request outputs depend on the state alone; key_clear
// is a one-cycle strobe on entry to a failure state.
// Assumes: violation inputs are already synchronous; fail states end only
// at reset.
module sec_state_fsm
    import sec_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_ext,
    input  logic       hw_viol,
    input  logic       sw_soft_fail,
    input  logic       sw_trust_wr,
    input  logic       sw_secure_wr,
    input  logic       hard_fail_en,
    output logic [2:0] state_o,
    output logic       key_test_en,
    output logic       key_master_en,
    output logic       key_clear,
    output logic       key_lockout,
    output logic       irq,
    output logic       reset_req,
    output logic       zeroize_req
);
    sec_state_e cur_q, nxt;
    logic       clr_q;
    logic       any_viol;
    sec_state_e fail_tgt;
    logic       cur_fail, nxt_fail;

    assign any_viol = hw_viol | sw_soft_fail;
    assign fail_tgt = hard_fail_en ? ST_HARDFAIL : ST_SOFTFAIL;

    // Next-state selection; violations are checked before software writes.
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_INIT:     nxt = ST_CHECK;
            ST_CHECK: begin
                if (any_viol || boot_ext) nxt = ST_NONSEC;
                else if (sw_trust_wr)     nxt = ST_TRUSTED;
            end
            ST_NONSEC:   nxt = ST_NONSEC;
            ST_TRUSTED: begin
                if (any_viol)          nxt = fail_tgt;
                else if (sw_secure_wr) nxt = ST_SECURE;
            end
            ST_SECURE: begin
                if (any_viol) nxt = fail_tgt;
            end
            ST_SOFTFAIL: begin
                if (any_viol && hard_fail_en) nxt = ST_HARDFAIL;
            end
            ST_HARDFAIL: nxt = ST_HARDFAIL;
            default:     nxt = ST_SOFTFAIL;
        endcase
    end

    assign cur_fail = (cur_q == ST_SOFTFAIL) || (cur_q == ST_HARDFAIL);
    assign nxt_fail = (nxt == ST_SOFTFAIL) || (nxt == ST_HARDFAIL);

    // State register and the key-clear entry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= ST_INIT;
            clr_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            clr_q <= nxt_fail && (nxt != cur_q);
        end
    end

    // Per-state key and request outputs.
    always_comb begin
        key_test_en   = (cur_q == ST_NONSEC);
        key_master_en = (cur_q == ST_TRUSTED) || (cur_q == ST_SECURE);
        key_lockout   = cur_fail;
        irq           = cur_fail;
        reset_req     = (cur_q == ST_HARDFAIL);
        zeroize_req   = (cur_q == ST_HARDFAIL);
    end

    assign key_clear = clr_q;
    assign state_o   = cur_q;

    // R1
    init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cur_q != ST_INIT);
    // R3
    key_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_test_en && key_master_en));
    // R5
    viol_trusted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q == ST_TRUSTED || cur_q == ST_SECURE) && any_viol)
        |=> (cur_q == ST_SOFTFAIL || cur_q == ST_HARDFAIL) && key_clear);
    // R6
    hard_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_HARDFAIL) |-> (reset_req && zeroize_req && key_lockout));
    // R7
    hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_HARDFAIL) |=> (cur_q == ST_HARDFAIL) && !key_clear);
    // R7
    soft_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_SOFTFAIL && !(any_viol && hard_fail_en))
        |=> (cur_q == ST_SOFTFAIL));
    // R11
    nonsec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_NONSEC) |=> (cur_q == ST_NONSEC));
endmodule

// File: rtl/sec_state_mon.sv
// Module: top of the security state monitor. It joins the tamper
// synchronizer, the monotonic counter and the state machine, and merges
// the hardware violation sources.
// Assumes: hash_fail and dbg_viol are synchronous to clk.
module sec_state_mon #(
    parameter int CNT_W       = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_ext,
    input  logic             tamper_n,
    input  logic             hash_fail,
    input  logic             dbg_viol,
    input  logic             cnt_inc,
    input  logic             sw_trust_wr,
    input  logic             sw_secure_wr,
    input  logic             sw_soft_fail,
    input  logic             hard_fail_en,
    output logic [2:0]       state_o,
    output logic             key_test_en,
    output logic             key_master_en,
    output logic             key_clear,
    output logic             key_lockout,
    output logic             irq,
    output logic             reset_req,
    output logic             zeroize_req,
    output logic [CNT_W-1:0] cnt_value
);
    logic tamper_viol;
    logic wrap_pulse;
    logic hw_viol;

    sec_tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tamper_n(tamper_n), .tamper_viol(tamper_viol)
    );

    sec_mono_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc),
        .value(cnt_value), .wrap_pulse(wrap_pulse)
    );

    assign hw_viol = tamper_viol | hash_fail | dbg_viol | wrap_pulse;

    sec_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .hw_viol(hw_viol),
        .sw_soft_fail(sw_soft_fail), .sw_trust_wr(sw_trust_wr),
        .sw_secure_wr(sw_secure_wr), .hard_fail_en(hard_fail_en),
        .state_o(state_o), .key_test_en(key_test_en),
        .key_master_en(key_master_en), .key_clear(key_clear),
        .key_lockout(key_lockout), .irq(irq), .reset_req(reset_req),
        .zeroize_req(zeroize_req)
    );
endmodule

// File: tb/sec_state_mon_tb.sv
module sec_state_mon_tb;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n, boot_ext, tamper_n, hash_fail, dbg_viol, cnt_inc;
    logic sw_trust_wr, sw_secure_wr, sw_soft_fail, hard_fail_en;
    logic [2:0] state_o;
    logic key_test_en, key_master_en, key_clear, key_lockout, irq;
    logic reset_req, zeroize_req;
    logic [CNT_W-1:0] cnt_value;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sec_state_mon #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .tamper_n(tamper_n),
        .hash_fail(hash_fail), .dbg_viol(dbg_viol), .cnt_inc(cnt_inc),
        .sw_trust_wr(sw_trust_wr), .sw_secure_wr(sw_secure_wr),
        .sw_soft_fail(sw_soft_fail), .hard_fail_en(hard_fail_en),
        .state_o(state_o), .key_test_en(key_test_en),
        .key_master_en(key_master_en), .key_clear(key_clear),
        .key_lockout(key_lockout), .irq(irq), .reset_req(reset_req),
        .zeroize_req(zeroize_req), .cnt_value(cnt_value)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        boot_ext = 0; tamper_n = 1; hash_fail = 0; dbg_viol = 0; cnt_inc = 0;
        sw_trust_wr = 0; sw_secure_wr = 0; sw_soft_fail = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    // target 3 = Trusted, 4 = Secure
    task automatic climb(input int target);
        do_reset();
        sw_trust_wr = 1; step(); sw_trust_wr = 0;
        if (target == 4) begin
            sw_secure_wr = 1; step(); sw_secure_wr = 0;
        end
    endtask

    task automatic fail_outputs(input string req, input int hf);
        chk(req, {29'd0, state_o}, hf ? 6 : 5);
        chk(req, key_master_en, 0);
        chk(req, key_test_en, 0);
        chk(req, key_lockout, 1);
        chk(req, irq, 1);
        chk(req, key_clear, 1);
        chk(req, reset_req, hf);
        chk(req, zeroize_req, hf);
        step();
        chk(req, key_clear, 0);
    endtask

    initial begin
        @(negedge clk);
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        hard_fail_en = 0;
        idle();
        rst_n = 0;
        @(negedge clk); step();
        // R1 reset state
        chk("R1 state", {29'd0, state_o}, 0);
        chk("R1 outs", {24'd0, key_test_en, key_master_en, key_clear, key_lockout,
                        irq, reset_req, zeroize_req, 1'b0}, 0);
        rst_n = 1; step();
        chk("R1 check", {29'd0, state_o}, 1);
        chk("R1 keys", {30'd0, key_test_en, key_master_en}, 0);

        // R2 external boot
        boot_ext = 1; step(); boot_ext = 0;
        chk("R2 boot", {29'd0, state_o}, 2);
        chk("R2 test", {30'd0, key_test_en, key_master_en}, 2);
        // R11 Non-Secure ignores everything
        sw_trust_wr = 1; hash_fail = 1; sw_soft_fail = 1; step(); idle();
        sw_secure_wr = 1; dbg_viol = 1; step(); idle();
        chk("R11 stay", {29'd0, state_o}, 2);
        chk("R11 irq", irq, 0);

        // R2 each violation source in Check
        for (int src = 0; src < 3; src++) begin
            do_reset();
            if (src == 0) hash_fail = 1;
            if (src == 1) dbg_viol = 1;
            if (src == 2) sw_soft_fail = 1;
            step(); idle();
            chk("R2 viol", {29'd0, state_o}, 2);
        end
        // R10 trust write against violation in Check
        do_reset();
        sw_trust_wr = 1; hash_fail = 1; step(); idle();
        chk("R10 check", {29'd0, state_o}, 2);

        // R4 secure write in Check ignored, then R3 climb
        do_reset();
        sw_secure_wr = 1; step(); sw_secure_wr = 0;
        chk("R4 check", {29'd0, state_o}, 1);
        sw_trust_wr = 1; step(); sw_trust_wr = 0;
        chk("R3 trusted", {29'd0, state_o}, 3);
        chk("R3 key", {30'd0, key_test_en, key_master_en}, 1);
        sw_trust_wr = 1; step(); sw_trust_wr = 0;
        chk("R4 trusted", {29'd0, state_o}, 3);
        sw_secure_wr = 1; step(); sw_secure_wr = 0;
        chk("R3 secure", {29'd0, state_o}, 4);
        chk("R3 key2", {30'd0, key_test_en, key_master_en}, 1);
        sw_trust_wr = 1; step(); sw_trust_wr = 0;
        chk("R4 secure", {29'd0, state_o}, 4);

        // R10 secure write against violation in Trusted
        hard_fail_en = 0;
        climb(3);
        sw_secure_wr = 1; dbg_viol = 1; step(); idle();
        chk("R10 trusted", {29'd0, state_o}, 5);

        // R5 R6 R8 R9 sweep: start state x source x response
        for (int st = 3; st <= 4; st++) begin
            for (int src = 0; src < 5; src++) begin
                for (int hf = 0; hf < 2; hf++) begin
                    hard_fail_en = hf[0];
                    climb(st);
                    case (src)
                        0: begin hash_fail = 1; step(); idle(); end
                        1: begin dbg_viol = 1; step(); idle(); end
                        2: begin sw_soft_fail = 1; step(); idle(); end
                        3: begin
                            tamper_n = 0; step(); step();
                            chk("R8 delay", {29'd0, state_o}, st);
                            step();
                        end
                        default: begin
                            cnt_inc = 1;
                            for (int i = 0; i < 15; i++) step();
                            chk("R9 count", {28'd0, cnt_value}, 15);
                            chk("R9 nowrap", {29'd0, state_o}, st);
                            step(); cnt_inc = 0;
                            chk("R9 wrap", {28'd0, cnt_value}, 0);
                            chk("R9 late", {29'd0, state_o}, st);
                            step();
                        end
                    endcase
                    fail_outputs(hf ? "R6 hard" : "R5 soft", hf);
                    idle();
                end
            end
        end

        // R7 soft fail escalates only with hard_fail_en
        hard_fail_en = 0;
        climb(4);
        hash_fail = 1; step(); idle();
        chk("R7 soft", {29'd0, state_o}, 5);
        sw_soft_fail = 1; step(); idle(); step();
        chk("R7 hold", {29'd0, state_o}, 5);
        hard_fail_en = 1;
        step();
        chk("R7 noviol", {29'd0, state_o}, 5);
        dbg_viol = 1; step(); idle();
        chk("R7 esc", {29'd0, state_o}, 6);
        chk("R7 clr", key_clear, 1);
        chk("R7 req", {30'd0, reset_req, zeroize_req}, 3);
        hash_fail = 1; sw_trust_wr = 1; step(); idle(); step();
        chk("R7 hardhold", {29'd0, state_o}, 6);
        chk("R7 clr0", key_clear, 0);

        // R1 reset clears a failure state
        do_reset();
        chk("R1 recover", {29'd0, state_o}, 1);
        chk("R1 req", {30'd0, reset_req, irq}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule